// File: doc/BRIEF.md
# Banked 24-bit Address Generator

This block turns the 16-bit quantities a small CPU works with into 24-bit bus addresses. It keeps three registers: a code bank, a data bank and a 16-bit direct-page base. It combines them with the program counter, an operand or base address and an index value, according to a 3-bit access-kind code supplied by the sequencer each cycle. Instruction fetches, data accesses, long accesses, direct-page accesses and stack accesses each follow their own rule for where the upper eight address bits come from.

The address and the extra-cycle flag depend only on the inputs and the current register values. The sequencer presents an access kind and reads the result in the same cycle. The three registers load through separate write ports at the rising clock edge. The code bank loads only through the long-jump port, so a program counter that rolls over never moves code into another bank. A direct-page base whose low byte is not zero raises a penalty flag, which tells the sequencer to add one cycle.

Top module: `bankAddrGen`

## Requirements
- R1: Access kind 0 (fetch) gives address {codeBank, pc}.
- R2: When pc goes from FFFF to 0000 between fetches, bits 23..16 keep the code bank value. The bank is never incremented.
- R3: Access kind 1 (absolute data) gives address {dataBank, baseAddr}.
- R4: Access kind 2 (indexed data) gives the 24-bit sum {dataBank, baseAddr} + idxVal, modulo 2^24, so a carry out of bit 15 raises the bank part of that address only. The stored data bank is left unchanged, as a later absolute access shows.
- R5: Access kind 3 (long) gives address {opBank, baseAddr}, whatever the data bank holds.
- R6: Access kind 4 (direct page) gives {00, (dpBase + baseAddr[7:0]) mod 2^16}.
- R7: Access kind 5 (stack) gives {00, baseAddr}, whatever the data bank holds.
- R8: dpPenalty is 1 exactly when the access kind is 4 and dpBase[7:0] is not zero. In every other case it is 0.
- R9: Reset (rstN low) clears the code bank and data bank to 00 and the direct-page base to 0000.
- R10: A write on pbWrEn, dbWrEn or dpWrEn loads the matching register at the rising edge. The new value is used from the following cycle on. No other input changes any of the three registers.
- R11: Access kinds 6 and 7 give address 000000 and dpPenalty 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| accKind | input | 3 | Access kind code (0 fetch, 1 absolute, 2 indexed, 3 long, 4 direct page, 5 stack) |
| pc | input | 16 | Program counter |
| baseAddr | input | 16 | Operand or base address. Bits 7..0 are the offset for direct page; for stack it is the stack pointer |
| idxVal | input | 16 | Index added for indexed data accesses |
| opBank | input | 8 | Bank byte of a long operand |
| pbWrEn | input | 1 | Long-jump load of the code bank |
| pbWrData | input | 8 | New code bank value |
| dbWrEn | input | 1 | Load of the data bank |
| dbWrData | input | 8 | New data bank value |
| dpWrEn | input | 1 | Load of the direct-page base |
| dpWrData | input | 16 | New direct-page base value |
| effAddr | output | 24 | Effective address |
| dpPenalty | output | 1 | Extra-cycle flag for unaligned direct page |

## Verification
The address and penalty flag are due in the same cycle as the access kind and operands, with no register in between. The bench therefore drives inputs on the falling edge and compares one nanosecond later, well before the next rising edge. A register write becomes visible one rising edge after it is presented. The bench's own register model is updated only after that edge, so every comparison uses the register values the design should hold in that cycle. Directed steps cover the bank-keeping rollover, carries across and past the top of the bank, direct-page wrap and reset values. Random steps then mix access kinds and writes.

// File: rtl/bankAddrGen_pkg.sv
package bankAddrGen_pkg;
  localparam int OFS_W  = 16;
  localparam int BANK_W = 8;
  localparam int DPO_W  = 8;
  localparam int FULL_W = OFS_W + BANK_W;

  typedef enum logic [2:0] {
    KIND_FETCH = 3'd0,
    KIND_ABS   = 3'd1,
    KIND_IDX   = 3'd2,
    KIND_LONG  = 3'd3,
    KIND_DP    = 3'd4,
    KIND_STACK = 3'd5,
    KIND_RSV6  = 3'd6,
    KIND_RSV7  = 3'd7
  } accKind_e;

  typedef enum logic [1:0] {
    BANK_CODE = 2'd0,
    BANK_DATA = 2'd1,
    BANK_OPND = 2'd2,
    BANK_ZERO = 2'd3
  } bankSel_e;

  typedef enum logic [1:0] {
    LOW_PC   = 2'd0,
    LOW_BASE = 2'd1,
    LOW_DP   = 2'd2,
    LOW_NONE = 2'd3
  } lowSel_e;

  typedef struct packed {
    bankSel_e bankSel;
    lowSel_e  lowSel;
    logic     addIdx;
    logic     chkPen;
  } addrCtl_t;
endpackage

// File: rtl/bankAddrGen_ctrl.sv
module bankAddrGen_ctrl
  import bankAddrGen_pkg::*;
(
  input  logic [2:0] accKind,
  output addrCtl_t   ctl
);
  accKind_e kindE;
  assign kindE = accKind_e'(accKind);

  always_comb begin
    ctl.bankSel = BANK_ZERO;
    ctl.lowSel  = LOW_NONE;
    ctl.addIdx  = 1'b0;
    ctl.chkPen  = 1'b0;
    case (kindE)
      KIND_FETCH: begin
        ctl.bankSel = BANK_CODE;
        ctl.lowSel  = LOW_PC;
      end
      KIND_ABS: begin
        ctl.bankSel = BANK_DATA;
        ctl.lowSel  = LOW_BASE;
      end
      KIND_IDX: begin
        ctl.bankSel = BANK_DATA;
        ctl.lowSel  = LOW_BASE;
        ctl.addIdx  = 1'b1;
      end
      KIND_LONG: begin
        ctl.bankSel = BANK_OPND;
        ctl.lowSel  = LOW_BASE;
      end
      KIND_DP: begin
        ctl.bankSel = BANK_ZERO;
        ctl.lowSel  = LOW_DP;
        ctl.chkPen  = 1'b1;
      end
      KIND_STACK: begin
        ctl.bankSel = BANK_ZERO;
        ctl.lowSel  = LOW_BASE;
      end
      default: begin
        ctl.bankSel = BANK_ZERO;
        ctl.lowSel  = LOW_NONE;
      end
    endcase
  end
endmodule

// File: rtl/bankAddrGen_dpath.sv
module bankAddrGen_dpath
  import bankAddrGen_pkg::*;
#(
  parameter int OW = OFS_W,
  parameter int BW = BANK_W,
  parameter int DW = DPO_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  addrCtl_t      ctl,
  input  logic [OW-1:0] pc,
  input  logic [OW-1:0] baseAddr,
  input  logic [OW-1:0] idxVal,
  input  logic [BW-1:0] opBank,
  input  logic          pbWrEn,
  input  logic [BW-1:0] pbWrData,
  input  logic          dbWrEn,
  input  logic [BW-1:0] dbWrData,
  input  logic          dpWrEn,
  input  logic [OW-1:0] dpWrData,
  output logic [OW+BW-1:0] effAddr,
  output logic          dpPenalty
);
  localparam int AW = OW + BW;

  logic [BW-1:0] codeBank, dataBank;
  logic [OW-1:0] dpBase;
  logic [BW-1:0] bankPick;
  logic [OW-1:0] lowPick;
  logic [OW-1:0] dpSum;
  logic [AW-1:0] idxSum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeBank <= '0;
      dataBank <= '0;
      dpBase   <= '0;
    end else begin
      if (pbWrEn) codeBank <= pbWrData;
      if (dbWrEn) dataBank <= dbWrData;
      if (dpWrEn) dpBase   <= dpWrData;
    end
  end

  assign dpSum  = dpBase + {{(OW-DW){1'b0}}, baseAddr[DW-1:0]};
  assign idxSum = {dataBank, baseAddr} + {{BW{1'b0}}, idxVal};

  always_comb begin
    case (ctl.bankSel)
      BANK_CODE: bankPick = codeBank;
      BANK_DATA: bankPick = dataBank;
      BANK_OPND: bankPick = opBank;
      default:   bankPick = '0;
    endcase
    case (ctl.lowSel)
      LOW_PC:   lowPick = pc;
      LOW_BASE: lowPick = baseAddr;
      LOW_DP:   lowPick = dpSum;
      default:  lowPick = '0;
    endcase
    if (ctl.addIdx) effAddr = idxSum;
    else            effAddr = {bankPick, lowPick};
  end

  assign dpPenalty = ctl.chkPen && (dpBase[DW-1:0] != '0);

  AST_PB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !pbWrEn |=> $stable(codeBank)); // R2
  AST_PB_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    pbWrEn |=> codeBank == $past(pbWrData)); // R10
  AST_DB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !dbWrEn |=> $stable(dataBank)); // R4
  AST_DP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !dpWrEn |=> $stable(dpBase)); // R10
endmodule

// File: rtl/bankAddrGen.sv
module bankAddrGen
  import bankAddrGen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  accKind,
  input  logic [15:0] pc,
  input  logic [15:0] baseAddr,
  input  logic [15:0] idxVal,
  input  logic [7:0]  opBank,
  input  logic        pbWrEn,
  input  logic [7:0]  pbWrData,
  input  logic        dbWrEn,
  input  logic [7:0]  dbWrData,
  input  logic        dpWrEn,
  input  logic [15:0] dpWrData,
  output logic [23:0] effAddr,
  output logic        dpPenalty
);
  addrCtl_t ctl;

  bankAddrGen_ctrl ctrl_i (
    .accKind (accKind),
    .ctl     (ctl)
  );

  bankAddrGen_dpath #(.OW(OFS_W), .BW(BANK_W), .DW(DPO_W)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .pc        (pc),
    .baseAddr  (baseAddr),
    .idxVal    (idxVal),
    .opBank    (opBank),
    .pbWrEn    (pbWrEn),
    .pbWrData  (pbWrData),
    .dbWrEn    (dbWrEn),
    .dbWrData  (dbWrData),
    .dpWrEn    (dpWrEn),
    .dpWrData  (dpWrData),
    .effAddr   (effAddr),
    .dpPenalty (dpPenalty)
  );

  AST_FETCH_LOW: assert property (@(posedge clk) disable iff (!rstN)
    accKind == 3'd0 |-> effAddr[15:0] == pc); // R1
  AST_LONG_BANK: assert property (@(posedge clk) disable iff (!rstN)
    accKind == 3'd3 |-> effAddr == {opBank, baseAddr}); // R5
  AST_BANK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (accKind == 3'd4 || accKind == 3'd5) |-> effAddr[23:16] == 8'h00); // R6
  AST_STACK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    accKind == 3'd5 |-> effAddr[15:0] == baseAddr); // R7
  AST_PEN_KIND: assert property (@(posedge clk) disable iff (!rstN)
    dpPenalty |-> accKind == 3'd4); // R8
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    accKind[2:1] == 2'b11 |-> (effAddr == 24'h0 && !dpPenalty)); // R11
endmodule

// File: tb/bankAddrGen_tb_top.sv
module bankAddrGen_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  accKind = '0;
  logic [15:0] pc = '0, baseAddr = '0, idxVal = '0, dpWrData = '0;
  logic [7:0]  opBank = '0, pbWrData = '0, dbWrData = '0;
  logic        pbWrEn = 1'b0, dbWrEn = 1'b0, dpWrEn = 1'b0;
  logic [23:0] effAddr;
  logic        dpPenalty;

  int total = 0;
  int bad = 0;
  logic [7:0]  mPb = '0, mDb = '0;
  logic [15:0] mDp = '0;

  always #2.5 clk = ~clk;

  bankAddrGen dut_i (
    .clk(clk), .rstN(rstN), .accKind(accKind), .pc(pc), .baseAddr(baseAddr),
    .idxVal(idxVal), .opBank(opBank), .pbWrEn(pbWrEn), .pbWrData(pbWrData),
    .dbWrEn(dbWrEn), .dbWrData(dbWrData), .dpWrEn(dpWrEn), .dpWrData(dpWrData),
    .effAddr(effAddr), .dpPenalty(dpPenalty)
  );

  function automatic logic [23:0] expAddr(input logic [2:0] k);
    logic [23:0] s;
    case (k)
      3'd0: return {mPb, pc};
      3'd1: return {mDb, baseAddr};
      3'd2: begin s = {mDb, baseAddr} + {8'h00, idxVal}; return s; end
      3'd3: return {opBank, baseAddr};
      3'd4: return {8'h00, 16'(mDp + {8'h00, baseAddr[7:0]})};
      3'd5: return {8'h00, baseAddr};
      default: return 24'h0;
    endcase
  endfunction

  function automatic logic expPen(input logic [2:0] k);
    return (k == 3'd4) && (mDp[7:0] != 8'h00);
  endfunction

  function automatic string reqOf(input logic [2:0] k);
    case (k)
      3'd0: return "R1";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic checkNow(input string req);
    logic [23:0] ea;
    logic        ep;
    ea = expAddr(accKind);
    ep = expPen(accKind);
    total++;
    if (effAddr !== ea) begin
      bad++;
      $display("FAIL %s addr kind=%0d got=%06h exp=%06h", req, accKind, effAddr, ea);
    end
    total++;
    if (dpPenalty !== ep) begin
      bad++;
      $display("FAIL R8 penalty kind=%0d got=%0b exp=%0b", accKind, dpPenalty, ep);
    end
  endtask

  // drive at falling edge, compare 1 ns later, then let the rising edge commit writes
  task automatic step(input logic [2:0] k, input logic [15:0] p, input logic [15:0] b,
                      input logic [15:0] ix, input logic [7:0] ob, input string req);
    @(negedge clk);
    accKind = k; pc = p; baseAddr = b; idxVal = ix; opBank = ob;
    #1 checkNow(req);
    @(posedge clk);
    if (pbWrEn) mPb = pbWrData;
    if (dbWrEn) mDb = dbWrData;
    if (dpWrEn) mDp = dpWrData;
    #0.5;
    pbWrEn = 1'b0; dbWrEn = 1'b0; dpWrEn = 1'b0;
  endtask

  task automatic writeRegs(input logic wp, input logic [7:0] vp, input logic wd,
                           input logic [7:0] vd, input logic wq, input logic [15:0] vq);
    @(negedge clk);
    pbWrEn = wp; pbWrData = vp; dbWrEn = wd; dbWrData = vd; dpWrEn = wq; dpWrData = vq;
    accKind = 3'd7;
    #1 checkNow("R11");
    @(posedge clk);
    if (wp) mPb = vp;
    if (wd) mDb = vd;
    if (wq) mDp = vq;
    #0.5;
    pbWrEn = 1'b0; dbWrEn = 1'b0; dpWrEn = 1'b0;
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : mainSeq
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R9 reset values seen through fetch, absolute and direct page
    step(3'd0, 16'h1234, 16'h0, 16'h0, 8'h0, "R9");
    step(3'd1, 16'h0, 16'h5678, 16'h0, 8'h0, "R9");
    step(3'd4, 16'h0, 16'h0012, 16'h0, 8'h0, "R9");
    // R10 code bank load, R2 rollover keeps the bank
    writeRegs(1'b1, 8'h7E, 1'b0, 8'h0, 1'b0, 16'h0);
    step(3'd0, 16'hFFFF, 16'h0, 16'h0, 8'h0, "R2");
    step(3'd0, 16'h0000, 16'h0, 16'h0, 8'h0, "R2");
    // R4 carry into bank, stored bank unchanged afterwards
    writeRegs(1'b0, 8'h0, 1'b1, 8'h12, 1'b0, 16'h0);
    step(3'd2, 16'h0, 16'hFFF0, 16'h0020, 8'h0, "R4");
    step(3'd1, 16'h0, 16'h0000, 16'h0, 8'h0, "R4");
    // R5 long ignores data bank, R7 stack in bank zero
    step(3'd3, 16'h0, 16'hABCD, 16'h0, 8'hC3, "R5");
    step(3'd5, 16'h0, 16'h01FF, 16'h0, 8'h0, "R7");
    // R4 wrap past the top of the 24-bit space
    writeRegs(1'b0, 8'h0, 1'b1, 8'hFF, 1'b0, 16'h0);
    step(3'd2, 16'h0, 16'hFFFF, 16'hFFFF, 8'h0, "R4");
    // R6/R8 unaligned and aligned direct page, 16-bit wrap
    writeRegs(1'b0, 8'h0, 1'b0, 8'h0, 1'b1, 16'h1280);
    step(3'd4, 16'h0, 16'h00FF, 16'h0, 8'h0, "R8");
    writeRegs(1'b0, 8'h0, 1'b0, 8'h0, 1'b1, 16'hFF00);
    step(3'd4, 16'h0, 16'h0080, 16'h0, 8'h0, "R8");
    writeRegs(1'b0, 8'h0, 1'b0, 8'h0, 1'b1, 16'hFFFF);
    step(3'd4, 16'h0, 16'h0002, 16'h0, 8'h0, "R6");
    step(3'd5, 16'h0, 16'h0002, 16'h0, 8'h0, "R8");
    step(3'd6, 16'h1111, 16'h2222, 16'h3, 8'h44, "R11");
    // random mix with writes (R10)
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      pbWrEn = ($urandom % 8) == 0; pbWrData = 8'($urandom);
      dbWrEn = ($urandom % 6) == 0; dbWrData = 8'($urandom);
      dpWrEn = ($urandom % 6) == 0;
      dpWrData = (($urandom % 2) == 0) ? {8'($urandom), 8'h00} : 16'($urandom);
      accKind = 3'($urandom); pc = 16'($urandom); baseAddr = 16'($urandom);
      idxVal = 16'($urandom); opBank = 8'($urandom);
      #1 checkNow(reqOf(accKind));
      @(posedge clk);
      if (pbWrEn) mPb = pbWrData;
      if (dbWrEn) mDb = dbWrData;
      if (dpWrEn) mDp = dpWrData;
      #0.5;
      pbWrEn = 1'b0; dbWrEn = 1'b0; dpWrEn = 1'b0;
    end
    // R10: writes land one edge later
    writeRegs(1'b1, 8'h3C, 1'b1, 8'h5A, 1'b1, 16'h0400);
    step(3'd0, 16'h0100, 16'h0, 16'h0, 8'h0, "R10");
    step(3'd1, 16'h0, 16'h0200, 16'h0, 8'h0, "R10");
    step(3'd4, 16'h0, 16'h0010, 16'h0, 8'h0, "R10");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule